// File: doc/BRIEF.md
# Active Priority Tracker

This block keeps the active-priority state of a single CPU interface in an interrupt controller. When the interface accepts an interrupt, the block receives its priority and group. It masks the priority down to a group priority using a binary point. It then marks the matching preemption level as active in one of two bitmaps: one for group 0 and one for group 1. The running priority becomes that group priority.

On end-of-interrupt (EOI), the block clears the most urgent active level in the bitmap of the completing interrupt's group. It then rebuilds the running priority from whatever levels are still active in either bitmap.

The running priority is the only output. An interface that decides whether a pending interrupt may preempt compares against it. The value 0x100 means nothing is active. Choosing the pending interrupt, the distributor and support for more than one CPU all live elsewhere.

Top module: `apt_tracker`

## Requirements
- R1: After reset, both bitmaps are empty and `running_prio` reads 0x100 (idle).
- R2: An accepted acknowledge sets `running_prio` to `{1'b0, group_priority}` on the next clock edge. An acknowledge is accepted when its ID is below `NUM_IRQ` and is not 1023.
- R3: The group priority is the 8-bit priority ANDed with 0xFF shifted left by (bp+1). With bp 0 the mask is 0xFE, with bp 3 it is 0xF0, and with bp 7 it is 0x00.
- R4: A group-1 acknowledge uses `abpr` when `cbpr` is 0 and `bpr` when `cbpr` is 1. A group-0 acknowledge always uses `bpr`.
- R5: An accepted EOI clears the lowest set bit of the first nonzero word in its group's bitmap. The running priority then becomes (lowest active level over both bitmaps) << (MIN_BPR+1), or 0x100 when no level is left. Nested acknowledges completed in reverse order therefore step the running priority back through the earlier values.
- R6: An EOI is ignored when `running_prio` is 0x100 or when its ID is `NUM_IRQ` or above.
- R7: With security support present (`HAS_SEC`=1), a non-secure EOI (`eoi_secure`=0) for a group-0 interrupt is ignored. A non-secure EOI for group 1 is accepted.
- R8: An acknowledge with ID 1023, or with an ID at or above `NUM_IRQ`, changes no state.
- R9: The preemption level is group_priority >> (MIN_BPR+1), and it is kept in the bitmap of the acknowledging interrupt's group. A group-0 EOI therefore leaves an active group-1 level in place, even when that level is more urgent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ack_valid | input | 1 | Acknowledge strobe |
| ack_id | input | 10 | Interrupt ID being acknowledged |
| ack_prio | input | 8 | Priority of the acknowledged interrupt |
| ack_group | input | 1 | Group of the acknowledged interrupt (1 = group 1) |
| eoi_valid | input | 1 | End-of-interrupt strobe |
| eoi_id | input | 10 | Interrupt ID being completed |
| eoi_group | input | 1 | Group of the completing interrupt |
| eoi_secure | input | 1 | Security attribute of the EOI access (1 = secure) |
| bpr | input | 3 | Main binary point |
| abpr | input | 3 | Aliased binary point for group 1 |
| cbpr | input | 1 | Use the main binary point for both groups |
| running_prio | output | 9 | Current running priority, 0x100 when idle |

## Verification
A wrong bit in either bitmap does not appear at once. It shows up only at a later EOI, when the rebuilt running priority lands on a level that should have been cleared, or skips one that should still be active. The bench therefore nests several acknowledges and then completes them in reverse order, checking `running_prio` one cycle after every strobe. It also completes a group-0 interrupt while a more urgent group-1 level is active, which exposes a clear made in the wrong bitmap on that very EOI. Masking errors show up directly on the acknowledge cycle, so each binary-point selection is driven with priorities whose low bits differ.

// File: rtl/apt_pkg.sv
package apt_pkg;

    localparam int          PRIO_W      = 8;
    localparam int          ID_W        = 10;
    localparam int          RP_W        = PRIO_W + 1;
    localparam logic [ID_W-1:0] SPURIOUS_ID = 10'd1023;
    localparam logic [RP_W-1:0] IDLE_PRIO   = 9'h100;

    // Request that marks one level active
    typedef struct packed {
        logic                  valid;
        logic                  grp1;
        logic [PRIO_W-1:0]     gprio;
    } act_req_t;

    // Request that retires one level
    typedef struct packed {
        logic valid;
        logic grp1;
    } drop_req_t;

    // Mask keeping the group-priority bits for binary point bp
    function automatic logic [PRIO_W-1:0] gp_mask(input logic [2:0] bp);
        logic [3:0] sh;
        sh = {1'b0, bp} + 4'd1;
        return 8'hFF << sh;
    endfunction

endpackage

// File: rtl/apt_group_prio.sv
module apt_group_prio
    import apt_pkg::*;
#(
    parameter int MIN_BPR    = 3,
    parameter bit HAS_GROUPS = 1'b1,
    localparam int LVL_W     = PRIO_W - (MIN_BPR + 1)
) (
    input  logic [PRIO_W-1:0] prio,
    input  logic              group_in,
    input  logic [2:0]        bpr,
    input  logic [2:0]        abpr,
    input  logic              cbpr,
    output logic              grp1,
    output logic [PRIO_W-1:0] gprio,
    output logic [LVL_W-1:0]  level
);

    logic [2:0] bp_sel;

    always_comb begin
        grp1   = HAS_GROUPS && group_in;
        bp_sel = (grp1 && !cbpr) ? abpr : bpr;
        gprio  = prio & gp_mask(bp_sel);
        level  = gprio[PRIO_W-1 -: LVL_W];
    end

endmodule

// File: rtl/apt_bank.sv
module apt_bank
    import apt_pkg::*;
#(
    parameter int NUM_REGS = 1,
    parameter int WORD_W   = 32,
    parameter int LVL_W    = 4,
    localparam int FLAT_W  = NUM_REGS * WORD_W
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic                             set_en,
    input  logic [LVL_W-1:0]                 set_level,
    input  logic                             drop_en,
    output logic [NUM_REGS-1:0][WORD_W-1:0]  q,
    output logic [NUM_REGS-1:0][WORD_W-1:0]  d
);

    logic [FLAT_W-1:0] set_vec;

    always_comb begin
        set_vec = '0;
        if (set_en) begin
            set_vec[set_level] = 1'b1;
        end
    end

    // Clear the lowest set bit of the first nonzero word, then merge the new level
    always_comb begin
        logic              seen;
        logic [WORD_W-1:0] w;
        seen = 1'b0;
        for (int r = 0; r < NUM_REGS; r++) begin
            w = q[r];
            if (drop_en && !seen && (|w)) begin
                w = w & (w - 1'b1);
            end
            seen = seen | (|q[r]);
            d[r] = w | set_vec[r*WORD_W +: WORD_W];
        end
    end

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_word
        always_ff @(posedge clk) begin
            if (rst) begin
                q[g] <= '0;
            end else begin
                q[g] <= d[g];
            end
        end
    end

endmodule

// File: rtl/apt_prio_scan.sv
module apt_prio_scan
    import apt_pkg::*;
#(
    parameter int NUM_REGS = 1,
    parameter int WORD_W   = 32,
    parameter int MIN_BPR  = 3
) (
    input  logic [NUM_REGS-1:0][WORD_W-1:0] bank0,
    input  logic [NUM_REGS-1:0][WORD_W-1:0] bank1,
    output logic [RP_W-1:0]                 prio
);

    logic [NUM_REGS-1:0][WORD_W-1:0] uni;

    always_comb begin
        logic [WORD_W-1:0] word;
        int                base;
        int                pos;
        logic              any;
        uni  = bank0 | bank1;
        word = '0;
        base = 0;
        any  = 1'b0;
        for (int r = NUM_REGS - 1; r >= 0; r--) begin
            if (|uni[r]) begin
                word = uni[r];
                base = r * WORD_W;
                any  = 1'b1;
            end
        end
        pos = 0;
        for (int b = WORD_W - 1; b >= 0; b--) begin
            if (word[b]) begin
                pos = b;
            end
        end
        prio = any ? RP_W'((base + pos) << (MIN_BPR + 1)) : IDLE_PRIO;
    end

endmodule

// File: rtl/apt_tracker.sv
module apt_tracker
    import apt_pkg::*;
#(
    parameter int NUM_IRQ    = 96,
    parameter int MIN_BPR    = 3,
    parameter int WORD_W     = 32,
    parameter bit HAS_GROUPS = 1'b1,
    parameter bit HAS_SEC    = 1'b1
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            ack_valid,
    input  logic [9:0]      ack_id,
    input  logic [7:0]      ack_prio,
    input  logic            ack_group,
    input  logic            eoi_valid,
    input  logic [9:0]      eoi_id,
    input  logic            eoi_group,
    input  logic            eoi_secure,
    input  logic [2:0]      bpr,
    input  logic [2:0]      abpr,
    input  logic            cbpr,
    output logic [8:0]      running_prio
);

    localparam int LVL_W      = PRIO_W - (MIN_BPR + 1);
    localparam int NUM_LEVELS = 1 << LVL_W;
    localparam int NUM_REGS   = (NUM_LEVELS + WORD_W - 1) / WORD_W;

    logic                            ack_grp1;
    logic [PRIO_W-1:0]               ack_gprio;
    logic [LVL_W-1:0]                ack_level;
    act_req_t                        act;
    drop_req_t                       drop;
    logic [NUM_REGS-1:0][WORD_W-1:0] b0_q, b0_d, b1_q, b1_d;
    logic [RP_W-1:0]                 scan_prio;
    logic [RP_W-1:0]                 rp_q;

    apt_group_prio #(
        .MIN_BPR   (MIN_BPR),
        .HAS_GROUPS(HAS_GROUPS)
    ) u_gprio (
        .prio    (ack_prio),
        .group_in(ack_group),
        .bpr     (bpr),
        .abpr    (abpr),
        .cbpr    (cbpr),
        .grp1    (ack_grp1),
        .gprio   (ack_gprio),
        .level   (ack_level)
    );

    always_comb begin
        act.valid  = ack_valid && (int'(ack_id) < NUM_IRQ) && (ack_id != SPURIOUS_ID);
        act.grp1   = ack_grp1;
        act.gprio  = ack_gprio;
        drop.grp1  = HAS_GROUPS && eoi_group;
        drop.valid = eoi_valid
                  && (int'(eoi_id) < NUM_IRQ)
                  && (rp_q != IDLE_PRIO)
                  && !(HAS_SEC && !eoi_secure && !drop.grp1);
    end

    apt_bank #(
        .NUM_REGS(NUM_REGS),
        .WORD_W  (WORD_W),
        .LVL_W   (LVL_W)
    ) u_bank0 (
        .clk      (clk),
        .rst      (rst),
        .set_en   (act.valid && !act.grp1),
        .set_level(ack_level),
        .drop_en  (drop.valid && !drop.grp1),
        .q        (b0_q),
        .d        (b0_d)
    );

    if (HAS_GROUPS) begin : g_bank1
        apt_bank #(
            .NUM_REGS(NUM_REGS),
            .WORD_W  (WORD_W),
            .LVL_W   (LVL_W)
        ) u_bank1 (
            .clk      (clk),
            .rst      (rst),
            .set_en   (act.valid && act.grp1),
            .set_level(ack_level),
            .drop_en  (drop.valid && drop.grp1),
            .q        (b1_q),
            .d        (b1_d)
        );
    end else begin : g_no_bank1
        assign b1_q = '0;
        assign b1_d = '0;
    end

    apt_prio_scan #(
        .NUM_REGS(NUM_REGS),
        .WORD_W  (WORD_W),
        .MIN_BPR (MIN_BPR)
    ) u_scan (
        .bank0(b0_d),
        .bank1(b1_d),
        .prio (scan_prio)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rp_q <= IDLE_PRIO;
        end else if (act.valid) begin
            rp_q <= {1'b0, act.gprio};
        end else if (drop.valid) begin
            rp_q <= scan_prio;
        end
    end

    assign running_prio = rp_q;

endmodule

// File: rtl/apt_tracker_chk.sv
module apt_tracker_chk #(
    parameter int NUM_IRQ    = 96,
    parameter int MIN_BPR    = 3,
    parameter bit HAS_GROUPS = 1'b1,
    parameter bit HAS_SEC    = 1'b1
) (
    input logic       clk,
    input logic       rst,
    input logic       ack_valid,
    input logic [9:0] ack_id,
    input logic       eoi_valid,
    input logic [9:0] eoi_id,
    input logic       eoi_group,
    input logic       eoi_secure,
    input logic [8:0] running_prio
);

    // R1
    reset_idle_chk: assert property (@(posedge clk)
        $past(rst) |-> running_prio == 9'h100);

    // R2
    ack_raises_chk: assert property (@(posedge clk) disable iff (rst)
        (ack_valid && int'(ack_id) < NUM_IRQ && ack_id != 10'd1023) |=> !running_prio[8]);

    // R8
    ack_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (ack_valid && (int'(ack_id) >= NUM_IRQ || ack_id == 10'd1023) && !eoi_valid)
        |=> $stable(running_prio));

    // R6
    eoi_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (eoi_valid && !ack_valid && running_prio == 9'h100) |=> running_prio == 9'h100);

    // R6
    eoi_range_chk: assert property (@(posedge clk) disable iff (rst)
        (eoi_valid && !ack_valid && int'(eoi_id) >= NUM_IRQ) |=> $stable(running_prio));

    // R7
    eoi_nonsec_chk: assert property (@(posedge clk) disable iff (rst)
        (eoi_valid && !ack_valid && HAS_SEC && !eoi_secure && !(HAS_GROUPS && eoi_group))
        |=> $stable(running_prio));

    // R5
    eoi_level_chk: assert property (@(posedge clk) disable iff (rst)
        (eoi_valid && !ack_valid)
        |=> (running_prio == 9'h100 || running_prio[MIN_BPR:0] == '0));

endmodule

bind apt_tracker apt_tracker_chk #(
    .NUM_IRQ   (NUM_IRQ),
    .MIN_BPR   (MIN_BPR),
    .HAS_GROUPS(HAS_GROUPS),
    .HAS_SEC   (HAS_SEC)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .ack_valid   (ack_valid),
    .ack_id      (ack_id),
    .eoi_valid   (eoi_valid),
    .eoi_id      (eoi_id),
    .eoi_group   (eoi_group),
    .eoi_secure  (eoi_secure),
    .running_prio(running_prio)
);

// File: tb/apt_tracker_tb.sv
`timescale 1ns/1ps
module apt_tracker_tb;

    localparam logic [1:0] OP_IDLE = 2'd0;
    localparam logic [1:0] OP_ACK  = 2'd1;
    localparam logic [1:0] OP_EOI  = 2'd2;

    typedef struct packed {
        logic [1:0] op;
        logic [9:0] id;
        logic [7:0] prio;
        logic       grp;
        logic       sec;
        logic [2:0] bp;
        logic [2:0] abp;
        logic       cbp;
        logic [8:0] exp;
        logic [3:0] req;
    } vec_t;

    localparam int NV = 26;
    localparam vec_t VEC [NV] = '{
        '{OP_ACK , 10'd5   , 8'hC0, 1'b0, 1'b0, 3'd3, 3'd3, 1'b0, 9'h0C0, 4'd2}, // R2
        '{OP_ACK , 10'd6   , 8'h80, 1'b1, 1'b0, 3'd3, 3'd3, 1'b0, 9'h080, 4'd4}, // R4
        '{OP_ACK , 10'd7   , 8'h45, 1'b0, 1'b0, 3'd3, 3'd3, 1'b0, 9'h040, 4'd3}, // R3
        '{OP_ACK , 10'd8   , 8'h10, 1'b1, 1'b0, 3'd3, 3'd3, 1'b0, 9'h010, 4'd2},
        '{OP_EOI , 10'd8   , 8'h00, 1'b1, 1'b0, 3'd3, 3'd3, 1'b0, 9'h040, 4'd5}, // R5
        '{OP_EOI , 10'd7   , 8'h00, 1'b0, 1'b0, 3'd3, 3'd3, 1'b0, 9'h040, 4'd7}, // R7
        '{OP_EOI , 10'd7   , 8'h00, 1'b0, 1'b1, 3'd3, 3'd3, 1'b0, 9'h080, 4'd5},
        '{OP_EOI , 10'd100 , 8'h00, 1'b1, 1'b1, 3'd3, 3'd3, 1'b0, 9'h080, 4'd6}, // R6
        '{OP_EOI , 10'd6   , 8'h00, 1'b1, 1'b1, 3'd3, 3'd3, 1'b0, 9'h0C0, 4'd5},
        '{OP_EOI , 10'd5   , 8'h00, 1'b0, 1'b1, 3'd3, 3'd3, 1'b0, 9'h100, 4'd5},
        '{OP_EOI , 10'd5   , 8'h00, 1'b0, 1'b1, 3'd3, 3'd3, 1'b0, 9'h100, 4'd6},
        '{OP_ACK , 10'd9   , 8'h6A, 1'b0, 1'b0, 3'd0, 3'd3, 1'b0, 9'h06A, 4'd3},
        '{OP_ACK , 10'd10  , 8'h5A, 1'b1, 1'b0, 3'd3, 3'd1, 1'b0, 9'h058, 4'd4},
        '{OP_ACK , 10'd11  , 8'h3F, 1'b1, 1'b0, 3'd2, 3'd7, 1'b1, 9'h038, 4'd4},
        '{OP_ACK , 10'd1023, 8'h00, 1'b0, 1'b0, 3'd3, 3'd3, 1'b0, 9'h038, 4'd8}, // R8
        '{OP_ACK , 10'd96  , 8'h00, 1'b0, 1'b0, 3'd3, 3'd3, 1'b0, 9'h038, 4'd8},
        '{OP_EOI , 10'd11  , 8'h00, 1'b1, 1'b1, 3'd3, 3'd3, 1'b0, 9'h050, 4'd5},
        '{OP_EOI , 10'd10  , 8'h00, 1'b1, 1'b1, 3'd3, 3'd3, 1'b0, 9'h060, 4'd5},
        '{OP_ACK , 10'd12  , 8'h7F, 1'b1, 1'b0, 3'd3, 3'd7, 1'b0, 9'h000, 4'd3},
        '{OP_EOI , 10'd12  , 8'h00, 1'b1, 1'b1, 3'd3, 3'd3, 1'b0, 9'h060, 4'd5},
        '{OP_EOI , 10'd9   , 8'h00, 1'b0, 1'b1, 3'd3, 3'd3, 1'b0, 9'h100, 4'd5},
        '{OP_ACK , 10'd20  , 8'h40, 1'b0, 1'b0, 3'd3, 3'd3, 1'b0, 9'h040, 4'd9}, // R9
        '{OP_ACK , 10'd21  , 8'h10, 1'b1, 1'b0, 3'd3, 3'd3, 1'b0, 9'h010, 4'd9},
        '{OP_EOI , 10'd20  , 8'h00, 1'b0, 1'b1, 3'd3, 3'd3, 1'b0, 9'h010, 4'd9},
        '{OP_EOI , 10'd21  , 8'h00, 1'b1, 1'b1, 3'd3, 3'd3, 1'b0, 9'h100, 4'd9},
        '{OP_IDLE, 10'd0   , 8'h00, 1'b0, 1'b0, 3'd3, 3'd3, 1'b0, 9'h100, 4'd1}
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ack_valid = 1'b0;
    logic [9:0] ack_id = '0;
    logic [7:0] ack_prio = '0;
    logic       ack_group = 1'b0;
    logic       eoi_valid = 1'b0;
    logic [9:0] eoi_id = '0;
    logic       eoi_group = 1'b0;
    logic       eoi_secure = 1'b0;
    logic [2:0] bpr = 3'd3;
    logic [2:0] abpr = 3'd3;
    logic       cbpr = 1'b0;
    logic [8:0] running_prio;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    apt_tracker u_dut (
        .clk         (clk),
        .rst         (rst),
        .ack_valid   (ack_valid),
        .ack_id      (ack_id),
        .ack_prio    (ack_prio),
        .ack_group   (ack_group),
        .eoi_valid   (eoi_valid),
        .eoi_id      (eoi_id),
        .eoi_group   (eoi_group),
        .eoi_secure  (eoi_secure),
        .bpr         (bpr),
        .abpr        (abpr),
        .cbpr        (cbpr),
        .running_prio(running_prio)
    );

    task automatic check(input string req, input logic [8:0] exp);
        checks++;
        if (running_prio !== exp) begin
            failures++;
            $display("FAIL %s: running_prio=0x%03h expected=0x%03h", req, running_prio, exp);
        end
    endtask

    // Drive one vector for one cycle, then sample after the edge
    task automatic apply(input vec_t v);
        ack_valid  = (v.op == OP_ACK);
        eoi_valid  = (v.op == OP_EOI);
        ack_id     = v.id;
        eoi_id     = v.id;
        ack_prio   = v.prio;
        ack_group  = v.grp;
        eoi_group  = v.grp;
        eoi_secure = v.sec;
        bpr        = v.bp;
        abpr       = v.abp;
        cbpr       = v.cbp;
        @(posedge clk);
        #1;
        ack_valid = 1'b0;
        eoi_valid = 1'b0;
        check($sformatf("R%0d", v.req), v.exp);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        rst = 1'b0;
        check("R1", 9'h100);
        for (int i = 0; i < NV; i++) begin
            apply(VEC[i]);
        end
        // R8: out-of-range acknowledge while idle
        apply('{OP_ACK, 10'd1023, 8'h00, 1'b0, 1'b0, 3'd3, 3'd3, 1'b0, 9'h100, 4'd8});
        // R1: reset while a level is active
        apply('{OP_ACK, 10'd5, 8'hC0, 1'b0, 1'b0, 3'd3, 3'd3, 1'b0, 9'h0C0, 4'd2});
        rst = 1'b1;
        @(posedge clk);
        #1;
        rst = 1'b0;
        check("R1", 9'h100);
        // R6: EOI after reset finds nothing active
        apply('{OP_EOI, 10'd5, 8'h00, 1'b0, 1'b1, 3'd3, 3'd3, 1'b0, 9'h100, 4'd6});
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(5.0 * 200000);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog: running_prio=0x%03h expected=completion", running_prio);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule